// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the coherence controller of one processor's private cache on a shared snooping bus. Lines move between four states: Invalid, Valid, Reserved and Dirty. The first store to a line held Valid goes out on the bus as a write-once transaction. That updates memory, invalidates copies in other caches, and leaves the line Reserved. A second store turns it Dirty, and from then on stores stay inside the cache until a write-back is needed.

The controller accepts one processor access at a time. It starts the bus transactions that an access or an eviction needs, and it watches the snoop inputs for transactions from other caches. When a snooped read or read-exclusive finds a Dirty line, the controller raises an inhibit output so that memory does not answer, writes the line back, and then demotes its own copy. Each line holds one data word and sits in a small direct-mapped array indexed by the low address bits. Arbitration sits outside the block. The bus is assumed to serialise transactions, so a snoop never arrives while this controller has its own transaction outstanding.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid. `bus_req`, `inhibit` and `cpu_done` are low, and the first access to any address misses.
- R2: A read hit returns the stored word with `cpu_done` high one cycle after the request is taken. It issues no bus transaction and leaves the line state unchanged. `cpu_done` is a single-cycle pulse.
- R3: A read miss issues a read (`bus_op`=0) at the request address. On `bus_ack` the line becomes Valid and `bus_rdata` is returned to the processor. Op and address stay stable while the request waits for acknowledge.
- R4: A write hit on a Valid line issues a write-once transaction (`bus_op`=2) that carries the address and the store data. On acknowledge the line becomes Reserved.
- R5: A write hit on a Reserved line updates the word locally and makes the line Dirty. A write hit on a Dirty line updates the word locally. Neither case uses the bus.
- R6: A write miss issues a read-exclusive (`bus_op`=1) at the request address. On acknowledge the line holds the store data and is Dirty.
- R7: A snooped read (`snp_op`=0) that hits a Dirty line raises `inhibit` in the same cycle. The controller then issues a write-back (`bus_op`=3) of the line's address and data, holds `inhibit` until that write-back is acknowledged, and leaves the line Valid.
- R8: A snooped read that hits a Reserved line demotes it to Valid without any bus transaction or inhibit.
- R9: A snooped read-exclusive (`snp_op`=1) or write-once (`snp_op`=2) that hits a line invalidates it. A read-exclusive that hits a Dirty line first writes it back under inhibit.
- R10: A miss whose victim line is Dirty first writes the victim back with its old address and data, then fetches the new line. A victim that is Reserved or Valid is replaced with no write-back.
- R11: When a snoop and a processor request arrive in the same cycle, the snoop is applied first. The processor access is served in a later cycle, against the state the snoop left.
- R12: A snooped write-back (`snp_op`=3) and a snoop whose tag does not match the line change nothing and raise no inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction request, held until `bus_ack` |
| bus_op | output | 2 | 0 read, 1 read-exclusive, 2 write-once, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Data for write-once and write-back |
| bus_ack | input | 1 | Completes the current transaction |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_ack` |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_op | input | 2 | Snooped op, encoded like `bus_op` |
| snp_addr | input | ADDR_W | Snooped address |
| inhibit | output | 1 | Keeps memory from answering while a Dirty copy is supplied |

## Verification
A snoop and a processor store can reach the same line in one cycle. This matters most when the line is Reserved, because the snoop demotes it while the store would otherwise dirty it silently. The bench sets up that collision by driving a snooped read and a store to the same Reserved line on the same edge. It passes only if exactly one write-once transaction with the store data appears, if `inhibit` stays low, and if a later store completes with no bus traffic. Separate scenarios cover a snoop against a Dirty line, checking that `inhibit` rises in the snoop cycle and is still high one cycle later, and a Dirty victim, checking that the write-back comes before the fill.

// File: rtl/wo_pkg.sv
// Shared encodings for the write-once coherence controller.
// Assumes the bus op encoding is shared by the master and snoop sides.
package wo_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_VAL = 2'd1,
        LS_RSV = 2'd2,
        LS_DRT = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_RDX   = 2'd1,
        OP_WONCE = 2'd2,
        OP_WB    = 2'd3
    } bus_op_t;

    typedef enum logic [2:0] {
        C_IDLE, C_FILL, C_EVWB, C_WONCE, C_SNPWB
    } ctrl_st_t;
endpackage

// File: rtl/wo_line_store.sv
// Direct-mapped line array: state, tag and one data word per line.
// One write port, two combinational read ports (processor side, snoop side).
// Only the state field is reset; tag and data are qualified by the state.
module wo_line_store
    import wo_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_t          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag
);
    localparam int LINES = 1 << IDX_W;

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line state register, cleared to Invalid by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[g] <= LS_INV;
            else if (wr_en && wr_idx == IDX_W'(g))
                st_q[g] <= wr_st;
        end

        // Per-line tag and data, no reset needed
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    // Read ports for the processor and snoop lookups
    always_comb begin
        a_st   = st_q[a_idx];
        a_tag  = tag_q[a_idx];
        a_data = data_q[a_idx];
        b_st   = st_q[b_idx];
        b_tag  = tag_q[b_idx];
    end
endmodule

// File: rtl/wo_snoop_eval.sv
// Judges one snooped transaction against the addressed line.
// Reports a hit, whether a write-back under inhibit is needed, and the
// state the line takes once the snoop has been served.
module wo_snoop_eval
    import wo_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_op_t          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             need_wb,
    output line_st_t         final_st
);
    // Hit test, write-back need and resulting state
    always_comb begin
        hit      = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag)
                   && (snp_op != OP_WB);
        need_wb  = hit && (line_st == LS_DRT)
                   && (snp_op == OP_RD || snp_op == OP_RDX);
        final_st = (snp_op == OP_RD) ? LS_VAL : LS_INV;
    end
endmodule

// File: rtl/wo_coherence_ctrl.sv
// Write-once snooping cache controller (top).
// Assumes: the processor holds its request stable until cpu_done; the bus
// serialises transactions, so snoops arrive only while this controller is
// idle; bus_ack is given only while bus_req is high.
module wo_coherence_ctrl
    import wo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              inhibit
);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctrl_st_t          fsm_q, fsm_d;
    logic              done_q, done_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [ADDR_W-1:0] wb_addr_q, wb_addr_d;
    logic [DATA_W-1:0] wb_data_q, wb_data_d;
    line_st_t          snp_fin_q, snp_fin_d;

    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_tag, s_tag;
    line_st_t          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data;
    logic              s_hit, s_need_wb;
    line_st_t          s_final;
    logic              c_hit;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_t          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];
    assign c_hit = (a_st != LS_INV) && (a_tag == c_tag);

    wo_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
        .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag)
    );

    wo_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid(snp_valid), .snp_op(bus_op_t'(snp_op)), .snp_tag(s_tag),
        .line_st(b_st), .line_tag(b_tag),
        .hit(s_hit), .need_wb(s_need_wb), .final_st(s_final)
    );

    // Next-state, line-store write and bookkeeping of pending write-backs
    always_comb begin
        fsm_d     = fsm_q;
        done_d    = 1'b0;
        rdata_d   = rdata_q;
        wb_addr_d = wb_addr_q;
        wb_data_d = wb_data_q;
        snp_fin_d = snp_fin_q;
        wr_en     = 1'b0;
        wr_idx    = c_idx;
        wr_st     = a_st;
        wr_tag    = a_tag;
        wr_data   = a_data;
        unique case (fsm_q)
            C_IDLE: begin
                if (snp_valid) begin
                    if (s_need_wb) begin
                        fsm_d     = C_SNPWB;
                        wb_addr_d = snp_addr;
                        wb_data_d = u_store.data_q[s_idx];
                        snp_fin_d = s_final;
                    end else if (s_hit) begin
                        wr_en   = 1'b1;
                        wr_idx  = s_idx;
                        wr_st   = s_final;
                        wr_tag  = b_tag;
                        wr_data = u_store.data_q[s_idx];
                    end
                end else if (cpu_req && !done_q) begin
                    if (c_hit && !cpu_we) begin
                        done_d  = 1'b1;
                        rdata_d = a_data;
                    end else if (c_hit && a_st == LS_VAL) begin
                        fsm_d = C_WONCE;
                    end else if (c_hit) begin
                        done_d  = 1'b1;
                        wr_en   = 1'b1;
                        wr_st   = LS_DRT;
                        wr_data = cpu_wdata;
                    end else if (a_st == LS_DRT) begin
                        fsm_d     = C_EVWB;
                        wb_addr_d = {a_tag, c_idx};
                        wb_data_d = a_data;
                    end else begin
                        fsm_d = C_FILL;
                    end
                end
            end
            C_EVWB: if (bus_ack) fsm_d = C_FILL;
            C_FILL: if (bus_ack) begin
                fsm_d   = C_IDLE;
                done_d  = 1'b1;
                rdata_d = bus_rdata;
                wr_en   = 1'b1;
                wr_tag  = c_tag;
                wr_st   = cpu_we ? LS_DRT : LS_VAL;
                wr_data = cpu_we ? cpu_wdata : bus_rdata;
            end
            C_WONCE: if (bus_ack) begin
                fsm_d   = C_IDLE;
                done_d  = 1'b1;
                wr_en   = 1'b1;
                wr_st   = LS_RSV;
                wr_data = cpu_wdata;
            end
            C_SNPWB: if (bus_ack) begin
                fsm_d   = C_IDLE;
                wr_en   = 1'b1;
                wr_idx  = wb_addr_q[IDX_W-1:0];
                wr_tag  = wb_addr_q[ADDR_W-1:IDX_W];
                wr_st   = snp_fin_q;
                wr_data = wb_data_q;
            end
            default: fsm_d = C_IDLE;
        endcase
    end

    // Controller registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q     <= C_IDLE;
            done_q    <= 1'b0;
            rdata_q   <= '0;
            wb_addr_q <= '0;
            wb_data_q <= '0;
            snp_fin_q <= LS_INV;
        end else begin
            fsm_q     <= fsm_d;
            done_q    <= done_d;
            rdata_q   <= rdata_d;
            wb_addr_q <= wb_addr_d;
            wb_data_q <= wb_data_d;
            snp_fin_q <= snp_fin_d;
        end
    end

    // Bus master outputs decoded from the controller state
    always_comb begin
        bus_req   = (fsm_q != C_IDLE);
        bus_op    = OP_RD;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        unique case (fsm_q)
            C_FILL:  bus_op = cpu_we ? OP_RDX : OP_RD;
            C_WONCE: bus_op = OP_WONCE;
            C_EVWB, C_SNPWB: begin
                bus_op    = OP_WB;
                bus_addr  = wb_addr_q;
                bus_wdata = wb_data_q;
            end
            default: bus_op = OP_RD;
        endcase
    end

    assign inhibit   = (fsm_q == C_SNPWB) || (fsm_q == C_IDLE && s_need_wb);
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    assert_inhibit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !(bus_req && bus_ack)) |=> inhibit);
    assert_inhibit_wb_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && bus_req) |-> (bus_op == OP_WB));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));
    assert_wonce_reserves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op == OP_WONCE && bus_ack) |=> (a_st == LS_RSV));
endmodule

// File: tb/wo_coherence_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module wo_coherence_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_done;
    logic          bus_req;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          inhibit;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [DW-1:0] mem [256];
    int            log_n = 0;
    logic [1:0]    log_op   [16];
    logic [AW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];

    always #2.5 clk = ~clk;

    wo_coherence_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr), .inhibit(inhibit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory side of the bus: log each transaction and acknowledge it
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i * 7);
        forever begin
            @(negedge clk);
            if (bus_req && !bus_ack) begin
                if (log_n < 16) begin
                    log_op[log_n]   = bus_op;
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                end
                log_n++;
                if (bus_op == 2'd2 || bus_op == 2'd3) mem[bus_addr] = bus_wdata;
                bus_rdata = mem[bus_addr];
                bus_ack   = 1'b1;
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int cyc);
        log_n = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_done && cyc < 50);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a, input bit exp_inh,
                         input string req);
        log_n = 0;
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        #1 chk(inhibit == exp_inh, req, "inhibit in snoop cycle", 32'(inhibit), 32'(exp_inh));
        @(negedge clk);
        snp_valid = 1'b0;
        #1 chk(inhibit == exp_inh, req, "inhibit one cycle later", 32'(inhibit), 32'(exp_inh));
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_and_read;
        logic [DW-1:0] rd; int cyc;
        chk(!bus_req && !inhibit && !cpu_done, "R1", "outputs after reset",
            {29'd0, bus_req, inhibit, cpu_done}, 0);
        access(0, 8'h01, 0, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd0 && log_addr[0] == 8'h01, "R3", "read miss op",
            32'(log_op[0]), 0);
        chk(rd == mem[8'h01], "R3", "read miss data", 32'(rd), 32'(mem[8'h01]));
        access(0, 8'h01, 0, rd, cyc);
        chk(cyc == 1 && log_n == 0, "R2", "read hit latency/bus", 32'(cyc), 1);
        chk(rd == mem[8'h01], "R2", "read hit data", 32'(rd), 32'(mem[8'h01]));
    endtask

    task automatic t_write_once;
        logic [DW-1:0] rd; int cyc;
        access(0, 8'h05, 0, rd, cyc);
        access(1, 8'h05, 16'hA001, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd2 && log_addr[0] == 8'h05 && log_data[0] == 16'hA001,
            "R4", "first write is write-once", 32'(log_op[0]), 2);
        access(1, 8'h05, 16'hA002, rd, cyc);
        chk(log_n == 0 && cyc == 1, "R5", "write on Reserved is local", 32'(log_n), 0);
        access(1, 8'h05, 16'hA003, rd, cyc);
        chk(log_n == 0 && cyc == 1, "R5", "write on Dirty is local", 32'(log_n), 0);
        access(0, 8'h05, 0, rd, cyc);
        chk(rd == 16'hA003 && log_n == 0, "R5", "latest local data", 32'(rd), 32'hA003);
    endtask

    task automatic t_write_miss;
        logic [DW-1:0] rd; int cyc;
        access(1, 8'h0A, 16'hB00B, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd1 && log_addr[0] == 8'h0A, "R6", "write miss op",
            32'(log_op[0]), 1);
        access(1, 8'h0A, 16'hB00C, rd, cyc);
        chk(log_n == 0, "R6", "line Dirty after write miss", 32'(log_n), 0);
    endtask

    task automatic t_snoop_dirty;
        logic [DW-1:0] rd; int cyc;
        snoop(2'd0, 8'h0A, 1'b1, "R7");
        chk(log_n == 1 && log_op[0] == 2'd3 && log_addr[0] == 8'h0A && log_data[0] == 16'hB00C,
            "R7", "write-back of dirty line", 32'(log_data[0]), 32'hB00C);
        access(0, 8'h0A, 0, rd, cyc);
        chk(log_n == 0 && rd == 16'hB00C, "R7", "copy kept after snoop read", 32'(rd), 32'hB00C);
        access(1, 8'h0A, 16'hC001, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd2, "R7", "line Valid after snoop", 32'(log_op[0]), 2);
    endtask

    task automatic t_snoop_reserved;
        logic [DW-1:0] rd; int cyc;
        snoop(2'd0, 8'h0A, 1'b0, "R8");
        chk(log_n == 0, "R8", "no bus on Reserved snoop", 32'(log_n), 0);
        access(1, 8'h0A, 16'hC002, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd2, "R8", "Reserved demoted to Valid", 32'(log_op[0]), 2);
    endtask

    task automatic t_snoop_inval;
        logic [DW-1:0] rd; int cyc;
        snoop(2'd1, 8'h05, 1'b1, "R9");
        chk(log_n == 1 && log_op[0] == 2'd3 && log_data[0] == 16'hA003, "R9",
            "read-exclusive flushes dirty", 32'(log_data[0]), 32'hA003);
        access(0, 8'h05, 0, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd0 && rd == 16'hA003, "R9", "line invalid after RDX",
            32'(log_n), 1);
        snoop(2'd2, 8'h01, 1'b0, "R9");
        access(0, 8'h01, 0, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd0, "R9", "line invalid after write-once", 32'(log_n), 1);
    endtask

    task automatic t_snoop_ignored;
        logic [DW-1:0] rd; int cyc;
        snoop(2'd3, 8'h01, 1'b0, "R12");
        access(0, 8'h01, 0, rd, cyc);
        chk(log_n == 0, "R12", "snooped write-back ignored", 32'(log_n), 0);
        access(1, 8'h0A, 16'hC003, rd, cyc);
        snoop(2'd0, 8'h4A, 1'b0, "R12");
        chk(log_n == 0, "R12", "tag mismatch snoop no bus", 32'(log_n), 0);
        access(1, 8'h0A, 16'hC004, rd, cyc);
        chk(log_n == 0, "R12", "line still Dirty", 32'(log_n), 0);
    endtask

    task automatic t_evict;
        logic [DW-1:0] rd; int cyc;
        access(1, 8'h13, 16'hD013, rd, cyc);
        access(0, 8'h23, 0, rd, cyc);
        chk(log_n == 2 && log_op[0] == 2'd3 && log_addr[0] == 8'h13 && log_data[0] == 16'hD013,
            "R10", "dirty victim written back first", 32'(log_addr[0]), 32'h13);
        chk(log_op[1] == 2'd0 && log_addr[1] == 8'h23, "R10", "fill after write-back",
            32'(log_addr[1]), 32'h23);
        access(1, 8'h23, 16'hD023, rd, cyc);
        access(0, 8'h33, 0, rd, cyc);
        chk(log_n == 1 && log_op[0] == 2'd0 && log_addr[0] == 8'h33, "R10",
            "Reserved victim silent", 32'(log_n), 1);
    endtask

    task automatic t_same_cycle;
        logic [DW-1:0] rd; int cyc;
        access(0, 8'h06, 0, rd, cyc);
        access(1, 8'h06, 16'hE001, rd, cyc);
        log_n = 0;
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'd0; snp_addr = 8'h06;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h06; cpu_wdata = 16'hE002;
        #1 chk(!inhibit, "R11", "no inhibit on Reserved", 32'(inhibit), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        cyc = 1;
        while (!cpu_done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        cpu_req = 1'b0;
        chk(log_n == 1 && log_op[0] == 2'd2 && log_data[0] == 16'hE002, "R11",
            "store after snoop goes write-once", 32'(log_n), 1);
        access(1, 8'h06, 16'hE003, rd, cyc);
        chk(log_n == 0, "R11", "line Reserved after collision", 32'(log_n), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_read();
        t_write_once();
        t_write_miss();
        t_snoop_dirty();
        t_snoop_reserved();
        t_snoop_inval();
        t_snoop_ignored();
        t_evict();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule